// File: doc/BRIEF.md
# Mixed-Sign Multiply-Accumulate Pipeline

This block forms the inner product of two integer vectors. It takes one element pair per clock. Each operand can be 8 or 16 bits wide and signed or unsigned, and each operand is set apart from the other. Every pair is widened to a common signed form and multiplied exactly. The product is then added into a 32-bit running sum. The sum is read as unsigned when both operands are unsigned, and as two's complement otherwise.

A start pulse clears the running sum and its status. It also discards any pair still inside the pipeline. A pair presented in the same cycle as the start pulse becomes the first term of the new sum. A marker on the final pair of a vector raises a done flag once that pair's product has reached the sum. A sticky flag records whether any addition left the 32-bit range that applies to its operand types. A stall input freezes every stage, and the computation carries on unchanged once the stall is released.

Top module: `ipmac_core`

## Requirements
- R1: After reset, acc_out is 0 and overflow, done and acc_signed are all 0.
- R2: A pair is accepted when in_valid is high and stall is low at a rising edge k. Its product appears in acc_out after edge k+2. One pair can be accepted at every edge.
- R3: When a_wide is 0, only a_data[7:0] is used and a_data[15:8] has no effect. When a_wide is 1, all 16 bits are used. The same rule applies to b_wide and b_data.
- R4: When a_signed is 1, the operand is two's complement. When a_signed is 0, the operand is unsigned. The same rule applies to b_signed. All four pairings give the exact product.
- R5: acc_out is the running sum modulo 2^32. acc_signed equals a_signed OR b_signed of the most recently accumulated pair.
- R6: overflow is set when an addition's exact result falls outside the 32-bit range of its mode. The range is [0, 2^32-1] when both operands are unsigned and [-2^31, 2^31-1] otherwise. The current sum is read in that same mode. The flag stays set until start.
- R7: A start pulse clears acc_out, overflow, done and acc_signed, and drops every pair in flight. A pair valid in the start cycle (with stall low) is accepted.
- R8: While stall is high, no pair is accepted and the pipeline, acc_out, overflow and done hold. After release, work resumes without loss. A start pulse during a stall still clears.
- R9: done rises in the same cycle that acc_out first includes the product of a pair marked by in_last. It stays high until start, or until a pair without in_last is accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clear the sum and flush the pipeline |
| stall | input | 1 | Freeze all stages |
| in_valid | input | 1 | Element pair present |
| in_last | input | 1 | Marks the final pair of a vector |
| a_data | input | 16 | First operand |
| b_data | input | 16 | Second operand |
| a_wide | input | 1 | First operand is 16 bits (1) or 8 bits (0) |
| b_wide | input | 1 | Second operand is 16 bits (1) or 8 bits (0) |
| a_signed | input | 1 | First operand is two's complement |
| b_signed | input | 1 | Second operand is two's complement |
| acc_out | output | 32 | Running sum |
| acc_signed | output | 1 | Sum is in two's complement |
| overflow | output | 1 | Sticky range overflow |
| done | output | 1 | Final pair has been accumulated |

## Verification
Clearing and accepting can happen in the same cycle. Every vector in the bench starts with its first pair sent together with the start pulse, while the previous vector's sum is still held. The final sum must therefore match a model that contains no trace of the earlier vector.

Start is also applied in two other situations:
- with pairs still in flight and no new pair, after which the sum must stay zero;
- during a stall, after which the clear must still appear.

Stall is checked in two places:
- in the middle of a vector, with junk pairs presented while stalled;
- just after the final pair, where the partial sum, the low done flag and the sum after release are each compared with the arithmetic model.

// File: rtl/ipmac_pkg.sv
package ipmac_pkg;
    localparam int DEF_OPW  = 16;
    localparam int DEF_ACCW = 32;
    localparam int NUM_OPS  = 2;

    function automatic int imax(int x, int y);
        return (x > y) ? x : y;
    endfunction
endpackage

// File: rtl/ipmac_operand.sv
module ipmac_operand #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  logic         wide,
    input  logic         sgn,
    output logic [W:0]   ext
);
    localparam int HW = W / 2;

    always_comb begin
        if (wide) begin
            ext = {sgn & din[W-1], din};
        end else begin
            ext = {{(HW + 1){sgn & din[HW-1]}}, din[HW-1:0]};
        end
    end
endmodule

// File: rtl/ipmac_mul_stage.sv
module ipmac_mul_stage #(
    parameter int EXW = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stall,
    input  logic                 flush,
    input  logic                 in_vld,
    input  logic                 in_last,
    input  logic                 in_sgn,
    input  logic [EXW-1:0]       a_ext,
    input  logic [EXW-1:0]       b_ext,
    output logic                 p_vld,
    output logic                 p_last,
    output logic                 p_sgn,
    output logic [2*EXW-1:0]     p_val
);
    localparam int PRODW = 2 * EXW;

    typedef struct packed {
        logic           vld;
        logic           last;
        logic           sgn;
        logic [EXW-1:0] a;
        logic [EXW-1:0] b;
    } opnd_t;

    typedef struct packed {
        logic             vld;
        logic             last;
        logic             sgn;
        logic [PRODW-1:0] p;
    } prod_t;

    typedef struct packed {
        opnd_t s0;
        prod_t s1;
    } pipe_t;

    pipe_t st_d, st_q;
    logic signed [PRODW-1:0] mul_d;

    always_comb begin
        mul_d = $signed({{EXW{st_q.s0.a[EXW-1]}}, st_q.s0.a})
              * $signed({{EXW{st_q.s0.b[EXW-1]}}, st_q.s0.b});
        st_d = st_q;
        if (!stall) begin
            st_d.s0.vld  = in_vld;
            st_d.s0.last = in_last;
            st_d.s0.sgn  = in_sgn;
            st_d.s0.a    = a_ext;
            st_d.s0.b    = b_ext;
            st_d.s1.vld  = st_q.s0.vld;
            st_d.s1.last = st_q.s0.last;
            st_d.s1.sgn  = st_q.s0.sgn;
            st_d.s1.p    = mul_d;
        end
        if (flush) begin
            st_d.s0.vld = in_vld & ~stall;
            st_d.s1.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign p_vld  = st_q.s1.vld;
    assign p_last = st_q.s1.last;
    assign p_sgn  = st_q.s1.sgn;
    assign p_val  = st_q.s1.p;

    // R8: stalled stages keep their contents
    a_r8_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> ($stable(st_q.s0) && $stable(st_q.s1)));
    // R7: a flush leaves nothing ready to accumulate
    a_r7_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !p_vld);
    // R2: an unstalled stage-one valid moves on to the product stage
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !flush && st_q.s0.vld) |=> p_vld);
endmodule

// File: rtl/ipmac_acc_stage.sv
module ipmac_acc_stage import ipmac_pkg::*; #(
    parameter int PRODW = 34,
    parameter int ACCW  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             clear,
    input  logic             p_vld,
    input  logic             p_last,
    input  logic             p_sgn,
    input  logic [PRODW-1:0] p_val,
    output logic [ACCW-1:0]  acc,
    output logic             ovf,
    output logic             done,
    output logic             res_sgn
);
    localparam int SUMW = imax(ACCW + 1, PRODW) + 1;
    localparam int TOPW = SUMW - ACCW + 1;

    typedef struct packed {
        logic [ACCW-1:0] acc;
        logic            ovf;
        logic            done;
        logic            sgn;
    } acc_t;

    acc_t st_d, st_q;
    logic [SUMW-1:0] base_d, term_d, sum_d;
    logic [TOPW-1:0] top_d;
    logic            range_bad_d;

    always_comb begin
        base_d = {{(SUMW - ACCW){p_sgn & st_q.acc[ACCW-1]}}, st_q.acc};
        term_d = {{(SUMW - PRODW){p_val[PRODW-1]}}, p_val};
        sum_d  = base_d + term_d;
        top_d  = sum_d[SUMW-1:ACCW-1];
        if (p_sgn) range_bad_d = !((&top_d) || !(|top_d));
        else       range_bad_d = |top_d[TOPW-1:1];

        st_d = st_q;
        if (!stall && p_vld) begin
            st_d.acc  = sum_d[ACCW-1:0];
            st_d.ovf  = st_q.ovf | range_bad_d;
            st_d.done = p_last;
            st_d.sgn  = p_sgn;
        end
        if (clear) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc     = st_q.acc;
    assign ovf     = st_q.ovf;
    assign done    = st_q.done;
    assign res_sgn = st_q.sgn;

    // R7: start empties the result
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0 && !ovf && !done && !res_sgn));
    // R6: overflow is sticky until cleared
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clear) |=> ovf);
    // R8: stall freezes the result
    a_r8_acc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !clear) |=> ($stable(acc) && $stable(ovf) && $stable(done)));
    // R9: done only rises for a marked product
    a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(p_vld && p_last && !stall));
    // R5: no product, no change
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_vld && !clear) |=> $stable(acc));
endmodule

// File: rtl/ipmac_core.sv
module ipmac_core import ipmac_pkg::*; #(
    parameter int OPW  = DEF_OPW,
    parameter int ACCW = DEF_ACCW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stall,
    input  logic            in_valid,
    input  logic            in_last,
    input  logic [OPW-1:0]  a_data,
    input  logic [OPW-1:0]  b_data,
    input  logic            a_wide,
    input  logic            b_wide,
    input  logic            a_signed,
    input  logic            b_signed,
    output logic [ACCW-1:0] acc_out,
    output logic            acc_signed,
    output logic            overflow,
    output logic            done
);
    localparam int EXW   = OPW + 1;
    localparam int PRODW = 2 * EXW;

    logic [OPW-1:0] op_din  [NUM_OPS];
    logic           op_wide [NUM_OPS];
    logic           op_sgn  [NUM_OPS];
    logic [EXW-1:0] op_ext  [NUM_OPS];

    assign op_din[0]  = a_data;
    assign op_din[1]  = b_data;
    assign op_wide[0] = a_wide;
    assign op_wide[1] = b_wide;
    assign op_sgn[0]  = a_signed;
    assign op_sgn[1]  = b_signed;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        ipmac_operand #(.W(OPW)) u_ext (
            .din  (op_din[g]),
            .wide (op_wide[g]),
            .sgn  (op_sgn[g]),
            .ext  (op_ext[g])
        );
    end

    logic             p_vld, p_last, p_sgn;
    logic [PRODW-1:0] p_val;

    ipmac_mul_stage #(.EXW(EXW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .flush   (start),
        .in_vld  (in_valid),
        .in_last (in_last),
        .in_sgn  (a_signed | b_signed),
        .a_ext   (op_ext[0]),
        .b_ext   (op_ext[1]),
        .p_vld   (p_vld),
        .p_last  (p_last),
        .p_sgn   (p_sgn),
        .p_val   (p_val)
    );

    ipmac_acc_stage #(.PRODW(PRODW), .ACCW(ACCW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .clear   (start),
        .p_vld   (p_vld),
        .p_last  (p_last),
        .p_sgn   (p_sgn),
        .p_val   (p_val),
        .acc     (acc_out),
        .ovf     (overflow),
        .done    (done),
        .res_sgn (acc_signed)
    );
endmodule

// File: tb/ipmac_core_tb.sv
module ipmac_core_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, start, stall, in_valid, in_last;
    logic [15:0] a_data, b_data;
    logic        a_wide, b_wide, a_signed, b_signed;
    logic [31:0] acc_out;
    logic        acc_signed, overflow, done;

    ipmac_core u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
        .in_valid(in_valid), .in_last(in_last), .a_data(a_data), .b_data(b_data),
        .a_wide(a_wide), .b_wide(b_wide), .a_signed(a_signed), .b_signed(b_signed),
        .acc_out(acc_out), .acc_signed(acc_signed), .overflow(overflow), .done(done)
    );

    localparam longint TWO32 = longint'(1) << 32;
    localparam longint MAXU  = TWO32 - 1;
    localparam longint MAXS  = (TWO32 >> 1) - 1;
    localparam longint MINS  = -(TWO32 >> 1);

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [15:0] va [0:255];
    logic [15:0] vb [0:255];
    longint exp_acc;
    bit exp_ovf;

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint bext(logic [15:0] v, bit w16, bit sg);
        longint r;
        if (w16) begin
            r = longint'(v);
            if (sg && v[15]) r -= 65536;
        end else begin
            r = longint'(v[7:0]);
            if (sg && v[7]) r -= 256;
        end
        return r;
    endfunction

    task automatic model(int n, bit aw, bit bw, bit as, bit bs);
        longint acc = 0;
        longint base, sum;
        bit s = as | bs;
        exp_ovf = 1'b0;
        for (int i = 0; i < n; i++) begin
            base = (s && acc > MAXS) ? acc - TWO32 : acc;
            sum = base + bext(va[i], aw, as) * bext(vb[i], bw, bs);
            if (s) begin
                if (sum > MAXS || sum < MINS) exp_ovf = 1'b1;
            end else if (sum < 0 || sum > MAXU) exp_ovf = 1'b1;
            acc = sum & MAXU;
        end
        exp_acc = acc;
    endtask

    // Each vector starts with its first pair in the start cycle (R7).
    task automatic run_vec(int n, bit aw, bit bw, bit as, bit bs,
                           int stall_at, bit tail, string tag);
        for (int i = 0; i < n; i++) begin
            if (i == stall_at) begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    start = 0; stall = 1; in_valid = 1; in_last = 1;
                    a_data = 16'hFFFF; b_data = 16'h8001;
                end
            end
            @(negedge clk);
            start = (i == 0); stall = 0; in_valid = 1; in_last = (i == n - 1);
            a_data = va[i]; b_data = vb[i];
            a_wide = aw; b_wide = bw; a_signed = as; b_signed = bs;
        end
        @(negedge clk);
        start = 0; in_valid = 0; in_last = 0; stall = tail;
        if (tail) begin
            repeat (4) @(posedge clk);
            @(negedge clk);
            model(n - 2, aw, bw, as, bs);
            check("R8 frozen sum", longint'(acc_out), exp_acc);
            check("R8 frozen done", longint'(done), 0);
            stall = 0;
        end
        @(posedge clk);
        @(negedge clk);
        model(n - 1, aw, bw, as, bs);
        check("R2 latency sum", longint'(acc_out), exp_acc);
        check("R2 latency done", longint'(done), 0);
        @(posedge clk);
        @(negedge clk);
        model(n, aw, bw, as, bs);
        check({tag, " sum"}, longint'(acc_out), exp_acc);
        check({tag, " overflow"}, longint'(overflow), longint'(exp_ovf));
        check("R9 done", longint'(done), 1);
        check("R5 signedness", longint'(acc_signed), longint'(as | bs));
    endtask

    task automatic set2(int i, logic [15:0] a, logic [15:0] b);
        va[i] = a;
        vb[i] = b;
    endtask

    initial begin
        rst_n = 0; start = 0; stall = 0; in_valid = 0; in_last = 0;
        a_data = 0; b_data = 0; a_wide = 0; b_wide = 0; a_signed = 0; b_signed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 sum", longint'(acc_out), 0);
        check("R1 overflow", longint'(overflow), 0);
        check("R1 done", longint'(done), 0);
        check("R1 signedness", longint'(acc_signed), 0);

        // R4 / R3: every width and signedness pairing, random data
        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 64; i++) begin
                va[i] = 16'($urandom);
                vb[i] = 16'($urandom);
            end
            run_vec(64, c[0], c[1], c[2], c[3], -1, 0, "R4");
        end

        // R3: byte sweep with junk in the upper bytes
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 256; i++) begin
                va[i] = 16'hC300 | 16'(i);
                vb[i] = 16'h5A00 | 16'((i * 37 + 11) & 255);
            end
            run_vec(256, 0, 0, s[0], s[1], -1, 0, "R3");
        end

        // R6: range edges
        set2(0, 16'hFFFF, 16'hFFFF); set2(1, 16'hFFFF, 16'h0002); set2(2, 16'h0001, 16'h0001);
        run_vec(2, 1, 1, 0, 0, -1, 0, "R6 unsigned top");
        check("R6 unsigned top exact", longint'(acc_out), MAXU);
        run_vec(3, 1, 1, 0, 0, -1, 0, "R6 unsigned wrap");
        check("R6 unsigned wrap flag", longint'(overflow), 1);

        set2(0, 16'h8000, 16'h8000); set2(1, 16'h7FFF, 16'h7FFF);
        set2(2, 16'h7FFF, 16'h0002); set2(3, 16'h0001, 16'h0001);
        run_vec(3, 1, 1, 1, 1, -1, 0, "R6 signed top");
        check("R6 signed top flag", longint'(overflow), 0);
        run_vec(4, 1, 1, 1, 1, -1, 0, "R6 signed past top");
        check("R6 signed past top flag", longint'(overflow), 1);

        set2(0, 16'h8000, 16'h7FFF); set2(1, 16'h8000, 16'h7FFF);
        set2(2, 16'h8000, 16'h0002); set2(3, 16'hFFFF, 16'h0001);
        run_vec(3, 1, 1, 1, 1, -1, 0, "R6 signed bottom");
        run_vec(4, 1, 1, 1, 1, -1, 0, "R6 signed past bottom");

        set2(0, 16'hFFFF, 16'h8000); set2(1, 16'hFFFF, 16'h8000);
        run_vec(2, 1, 1, 0, 1, -1, 0, "R6 mixed");
        check("R6 mixed flag", longint'(overflow), 1);

        set2(0, 16'hFFFF, 16'hFFFF); set2(1, 16'hFFFF, 16'hFFFF); set2(2, 16'h0001, 16'h0001);
        run_vec(3, 1, 1, 0, 0, -1, 0, "R6 sticky");
        check("R6 sticky flag", longint'(overflow), 1);

        // R8: stall mid-vector with junk offered, and stall after the last pair
        for (int i = 0; i < 16; i++) begin
            va[i] = 16'($urandom);
            vb[i] = 16'($urandom);
        end
        run_vec(16, 1, 0, 0, 1, 5, 1, "R8");

        // R7: start with pairs in flight and no new pair
        @(negedge clk);
        start = 1; in_valid = 1; in_last = 0; a_data = 16'd100; b_data = 16'd3;
        @(negedge clk);
        start = 0; a_data = 16'd7; b_data = 16'd9;
        @(negedge clk);
        start = 1; in_valid = 0;
        @(negedge clk);
        start = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 flushed sum", longint'(acc_out), 0);
        check("R7 flushed done", longint'(done), 0);
        check("R7 flushed overflow", longint'(overflow), 0);

        // R8: start while stalled still clears
        set2(0, 16'h0123, 16'h0045);
        run_vec(1, 1, 1, 0, 0, -1, 0, "R8 prep");
        @(negedge clk);
        stall = 1; start = 1;
        @(negedge clk);
        start = 0;
        check("R8 clear in stall sum", longint'(acc_out), 0);
        check("R8 clear in stall done", longint'(done), 0);
        stall = 0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule